// File: doc/BRIEF.md
# Byte Serial Port with Two-Step Status Flags

This block is a byte-wide synchronous serial port that can act as bus master or as a selected slave. A processor reaches it through three registers (control, status and data) on a small select/write bus. In master mode a data write starts an eight-bit exchange. The port drives the serial clock at a rate picked from four dividers of the system clock, sends the most significant bit first and collects the returning bits into a receive register. In slave mode the serial clock and the active-low select come from the pins through synchronizers.

Three status flags report the port's condition: exchange finished, write collided with a running exchange, and select asserted while the port was the master. None of them clears on a plain read. A flag is armed by a status read that sees it set, and it is then cleared by a second access of a given kind. The interrupt line combines the finished and fault flags under an enable bit.

Register map: address 0 is control (bit 0 port enable, bit 1 master select, bit 2 interrupt enable, bits 5:4 rate code, all other bits read zero). Address 1 is status. Address 2 is data (a write loads the transmit byte, a read returns the last received byte). Address 3 reads zero.

Top module: `spi_port_ctrl`

## Requirements
- R1: After reset the control and status registers read 0x00, irq is low, and sck_oe and ser_oe are low.
- R2: In master mode the rate code sets the serial clock period to 2, 4, 16 or 32 system clocks for codes 0, 1, 2 and 3. With half period H clocks, the finished flag is set exactly 16*H clock edges after the edge that accepts the data write.
- R3: Bits go out on ser_out most significant first. The serial clock idles low, ser_in is sampled on its rising edge, and after the exchange a data read returns the collected byte.
- R4: Status bit 7 is the finished flag. It sets when the eighth serial clock period completes. Status bits 5 and 3:0 always read zero.
- R5: The finished flag clears only after a status read that sees it set, followed by a read or write of the data register. A data access without the preceding status read leaves it set.
- R6: A data write while an exchange is running is discarded: the byte being shifted is unchanged. The write sets status bit 6 (collision), and the collision flag never drives irq.
- R7: The collision flag clears after a status read that sees it set, followed by any data register access.
- R8: When the synchronized select input is low while the master bit is set, status bit 4 (mode fault) sets three edges after the pin falls. The same event clears the enable and master bits, which releases sck_oe and ser_oe.
- R9: The mode fault flag clears only after a status read that sees it set, followed by a control register write. Data accesses and a control write without the armed read leave it set.
- R10: irq is high exactly when the interrupt enable bit is set and the finished or mode fault flag is set.
- R11: With the port enabled and the master bit clear, an exchange advances on the synchronized sck_in edges only while ss_n is low. Serial clock pulses with ss_n high are ignored. The slave shifts the preloaded byte out on ser_out and sets the finished flag after eight bits.
- R12: An armed flag stays armed across accesses of other kinds until its clearing access arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | BYTE_W | Write data |
| bus_rdata | output | BYTE_W | Read data for the addressed register (combinational) |
| irq | output | 1 | Interrupt request |
| sck_in | input | 1 | Serial clock from the pin (slave mode) |
| sck_out | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Drive enable for sck_out |
| ss_n | input | 1 | Active-low select pin |
| ser_in | input | 1 | Serial data into the port |
| ser_out | output | 1 | Serial data out of the port |
| ser_oe | output | 1 | Drive enable for ser_out |

## Verification
Register reads are combinational, so the bench samples bus_rdata half a cycle before the accepting edge, and each access takes its side effects on that edge. For a master exchange the bench counts 16*H-1 edges after the write edge and expects irq still low, then one more edge and expects it high. A mode fault is due on the third edge after ss_n falls (two synchronizer stages plus the flag register), so irq is sampled after the second and after the third edge. All sampling happens on the falling clock edge, away from the edges where the design updates.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
   localparam logic [1:0] ADR_CTRL = 2'd0;
   localparam logic [1:0] ADR_STAT = 2'd1;
   localparam logic [1:0] ADR_DATA = 2'd2;

   // control bit positions
   localparam int CB_EN   = 0;
   localparam int CB_MST  = 1;
   localparam int CB_IE   = 2;
   localparam int CB_RATE = 4;

   // status bit positions
   localparam int SB_DONE = 7;
   localparam int SB_WCOL = 6;
   localparam int SB_MODF = 4;

   // flag slots in the flag vector
   localparam int FL_DONE = 0;
   localparam int FL_WCOL = 1;
   localparam int FL_MODF = 2;
   localparam int FL_NUM  = 3;

   // half period of master serial clock, in system clocks
   function automatic int half_period(input logic [1:0] code);
      case (code)
         2'd0:    return 1;
         2'd1:    return 2;
         2'd2:    return 8;
         default: return 16;
      endcase
   endfunction
endpackage

// File: rtl/spi_port_clkdiv.sv
module spi_port_clkdiv #(
   parameter int CNT_W = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [1:0] rate,
   output logic       tick
);
   import spi_port_pkg::*;

   if (CNT_W < 4) begin : g_bad_width
      $error("spi_port_clkdiv: CNT_W must hold a count of 15");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;

   assign limit = CNT_W'(half_period(rate) - 1);
   assign tick  = run && (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (!run)  cnt_q <= '0;
      else if (tick)  cnt_q <= '0;
      else            cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/spi_port_shifter.sv
module spi_port_shifter #(
   parameter int W        = 8,
   parameter bit SLAVE_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         master,
   input  logic         tick,
   input  logic         start,
   input  logic         abort,
   input  logic [W-1:0] tx_data,
   input  logic         sck_s,
   input  logic         ss_s,
   input  logic         ser_in,
   output logic         busy,
   output logic         sck_q,
   output logic         ser_bit,
   output logic         fin,
   output logic [W-1:0] rx_data
);
   localparam int BW = $clog2(W) + 1;

   if (W < 2) begin : g_bad_w
      $error("spi_port_shifter: W must be at least 2");
   end

   logic [W-1:0]  sh_q, rx_q, shift_in;
   logic          cap_q, busy_q, sck_r;
   logic [BW-1:0] bit_q;
   logic          s_rise, s_fall, s_act;
   logic          m_rise, m_fall, last;

   if (SLAVE_EN) begin : g_slave
      logic sck_d;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sck_d <= 1'b0;
         else        sck_d <= sck_s;
      end
      assign s_act  = en && !master && !ss_s;
      assign s_rise = s_act && sck_s && !sck_d;
      assign s_fall = s_act && !sck_s && sck_d;
   end else begin : g_no_slave
      assign s_act  = 1'b0;
      assign s_rise = 1'b0;
      assign s_fall = 1'b0;
   end

   assign m_rise   = busy_q && tick && !sck_r;
   assign m_fall   = busy_q && tick && sck_r;
   assign shift_in = {sh_q[W-2:0], cap_q};
   assign last     = (bit_q == BW'(W-1));
   assign fin      = (m_fall || s_fall) && last && !abort;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         rx_q   <= '0;
         cap_q  <= 1'b0;
         busy_q <= 1'b0;
         sck_r  <= 1'b0;
         bit_q  <= '0;
      end else if (abort) begin
         busy_q <= 1'b0;
         sck_r  <= 1'b0;
         bit_q  <= '0;
      end else if (start) begin
         sh_q   <= tx_data;
         bit_q  <= '0;
         busy_q <= master;
         sck_r  <= 1'b0;
      end else begin
         if (m_rise || s_rise) begin
            cap_q <= ser_in;
            if (m_rise) sck_r <= 1'b1;
         end
         if (m_fall || s_fall) begin
            sh_q  <= shift_in;
            sck_r <= 1'b0;
            if (last) begin
               bit_q  <= '0;
               busy_q <= 1'b0;
               rx_q   <= shift_in;
            end else begin
               bit_q <= bit_q + 1'b1;
            end
         end
         if (!master && !s_act) bit_q <= '0;
      end
   end

   assign busy    = busy_q || (!master && (bit_q != '0));
   assign sck_q   = sck_r;
   assign ser_bit = sh_q[W-1];
   assign rx_data = rx_q;
endmodule

// File: rtl/spi_port_flag.sv
module spi_port_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic arm_i,
   input  logic clr_i,
   output logic flag_o
);
   logic flag_q, armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q  <= 1'b0;
         armed_q <= 1'b0;
      end else if (set_i) begin
         flag_q  <= 1'b1;
         armed_q <= 1'b0;
      end else if (arm_i) begin
         armed_q <= flag_q;
      end else if (armed_q && clr_i) begin
         flag_q  <= 1'b0;
         armed_q <= 1'b0;
      end
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl #(
   parameter int BYTE_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int DIV_W       = 4,
   parameter bit SLAVE_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [1:0]        bus_addr,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   output logic              irq,
   input  logic              sck_in,
   output logic              sck_out,
   output logic              sck_oe,
   input  logic              ss_n,
   input  logic              ser_in,
   output logic              ser_out,
   output logic              ser_oe
);
   import spi_port_pkg::*;

   if (BYTE_W < 8) begin : g_bad_byte
      $error("spi_port_ctrl: BYTE_W must be at least 8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("spi_port_ctrl: SYNC_STAGES must be at least 2");
   end

   localparam logic [BYTE_W-1:0] CTRL_MASK = BYTE_W'(8'h37);

   // pin synchronizers
   logic [SYNC_STAGES-1:0] sck_sy, ss_sy;
   logic sck_s, ss_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_sy <= '0;
         ss_sy  <= '1;
      end else begin
         sck_sy <= {sck_sy[SYNC_STAGES-2:0], sck_in};
         ss_sy  <= {ss_sy[SYNC_STAGES-2:0], ss_n};
      end
   end
   assign sck_s = sck_sy[SYNC_STAGES-1];
   assign ss_s  = ss_sy[SYNC_STAGES-1];

   // bus decode
   logic rd, wr, ctrl_wr, stat_rd, data_acc, data_wr;
   assign rd       = bus_sel && !bus_wr;
   assign wr       = bus_sel && bus_wr;
   assign ctrl_wr  = wr && (bus_addr == ADR_CTRL);
   assign stat_rd  = rd && (bus_addr == ADR_STAT);
   assign data_acc = bus_sel && (bus_addr == ADR_DATA);
   assign data_wr  = wr && (bus_addr == ADR_DATA);

   // control register
   logic [BYTE_W-1:0] ctrl_q;
   logic ctl_en, ctl_mst, ctl_ie;
   logic [1:0] ctl_rate;
   logic modf_evt;

   assign ctl_en   = ctrl_q[CB_EN];
   assign ctl_mst  = ctrl_q[CB_MST];
   assign ctl_ie   = ctrl_q[CB_IE];
   assign ctl_rate = ctrl_q[CB_RATE+1:CB_RATE];
   assign modf_evt = ctl_mst && !ss_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (modf_evt) begin
         ctrl_q[CB_EN]  <= 1'b0;
         ctrl_q[CB_MST] <= 1'b0;
      end else if (ctrl_wr) begin
         ctrl_q <= bus_wdata & CTRL_MASK;
      end
   end

   // shift engine and divider
   logic busy, tick, fin, sck_q, ser_bit, start, wcol_evt;
   logic [BYTE_W-1:0] rx_data;

   assign start    = data_wr && !busy && ctl_en;
   assign wcol_evt = data_wr && busy;

   spi_port_clkdiv #(.CNT_W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy && ctl_mst),
      .rate  (ctl_rate),
      .tick  (tick)
   );

   spi_port_shifter #(.W(BYTE_W), .SLAVE_EN(SLAVE_EN)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (ctl_en),
      .master  (ctl_mst),
      .tick    (tick),
      .start   (start),
      .abort   (modf_evt || !ctl_en),
      .tx_data (bus_wdata),
      .sck_s   (sck_s),
      .ss_s    (ss_s),
      .ser_in  (ser_in),
      .busy    (busy),
      .sck_q   (sck_q),
      .ser_bit (ser_bit),
      .fin     (fin),
      .rx_data (rx_data)
   );

   // status flags
   logic [FL_NUM-1:0] set_v, clr_v, flag_q;
   assign set_v[FL_DONE] = fin;
   assign set_v[FL_WCOL] = wcol_evt;
   assign set_v[FL_MODF] = modf_evt;
   assign clr_v[FL_DONE] = data_acc;
   assign clr_v[FL_WCOL] = data_acc;
   assign clr_v[FL_MODF] = ctrl_wr;

   for (genvar i = 0; i < FL_NUM; i++) begin : g_flag
      spi_port_flag u_flag (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (set_v[i]),
         .arm_i  (stat_rd),
         .clr_i  (clr_v[i]),
         .flag_o (flag_q[i])
      );
   end

   logic [BYTE_W-1:0] status;
   always_comb begin
      status          = '0;
      status[SB_DONE] = flag_q[FL_DONE];
      status[SB_WCOL] = flag_q[FL_WCOL];
      status[SB_MODF] = flag_q[FL_MODF];
   end

   always_comb begin
      case (bus_addr)
         ADR_CTRL: bus_rdata = ctrl_q;
         ADR_STAT: bus_rdata = status;
         ADR_DATA: bus_rdata = rx_data;
         default:  bus_rdata = '0;
      endcase
   end

   assign irq     = ctl_ie && (flag_q[FL_DONE] || flag_q[FL_MODF]);
   assign sck_out = sck_q;
   assign sck_oe  = ctl_en && ctl_mst;
   assign ser_out = ser_bit;
   assign ser_oe  = ctl_en && (ctl_mst || !ss_s);
endmodule

// File: rtl/spi_port_ctrl_chk.sv
module spi_port_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic irq,
   input logic sck_out,
   input logic ctrl_en,
   input logic ctrl_mst,
   input logic busy,
   input logic data_wr,
   input logic data_acc,
   input logic ctrl_wr,
   input logic f_done,
   input logic f_wcol,
   input logic f_modf
);
   assert_sck_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sck_out);

   assert_done_clear_path_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(f_done) |-> $past(data_acc));

   assert_wcol_on_busy_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && busy) |=> f_wcol);

   assert_wcol_no_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (f_wcol && !f_done && !f_modf) |-> !irq);

   assert_wcol_clear_path_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(f_wcol) |-> $past(data_acc));

   assert_modf_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(f_modf) |-> (!ctrl_en && !ctrl_mst));

   assert_modf_clear_path_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(f_modf) |-> $past(ctrl_wr));
endmodule

bind spi_port_ctrl spi_port_ctrl_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .irq      (irq),
   .sck_out  (sck_out),
   .ctrl_en  (ctrl_q[0]),
   .ctrl_mst (ctrl_q[1]),
   .busy     (busy),
   .data_wr  (data_wr),
   .data_acc (data_acc),
   .ctrl_wr  (ctrl_wr),
   .f_done   (flag_q[0]),
   .f_wcol   (flag_q[1]),
   .f_modf   (flag_q[2])
);

// File: tb/spi_port_ctrl_test.sv
module spi_port_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_wr = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       irq, sck_out, sck_oe, ser_out, ser_oe;
   logic       sck_in = 1'b0, ss_n = 1'b1;
   logic       use_ext = 1'b0, loop_inv = 1'b0, ext_bit = 1'b0;
   logic       ser_in;

   int n_chk = 0;
   int n_bad = 0;

   assign ser_in = use_ext ? ext_bit : (loop_inv ? ~ser_out : ser_out);

   always #4 clk = ~clk;

   spi_port_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
      .ss_n(ss_n), .ser_in(ser_in), .ser_out(ser_out), .ser_oe(ser_oe)
   );

   // {rate[1:0], invert, 5'b0, tx[7:0], expected rx[7:0]}
   localparam logic [23:0] VEC [4] = '{
      {2'd0, 1'b0, 5'd0, 8'hA5, 8'hA5},
      {2'd1, 1'b1, 5'd0, 8'h3C, 8'hC3},
      {2'd2, 1'b0, 5'd0, 8'h81, 8'h81},
      {2'd3, 1'b1, 5'd0, 8'h0F, 8'hF0}
   };

   function automatic int half_of(input logic [1:0] r);
      case (r)
         2'd0: return 1;
         2'd1: return 2;
         2'd2: return 8;
         default: return 16;
      endcase
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      finish_run();
   end

   initial begin
      logic [7:0] rd;
      logic [7:0] obs;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      bus_read(2'd0, rd);  check("R1 ctrl after reset", rd, 8'h00);
      bus_read(2'd1, rd);  check("R1 status after reset", rd, 8'h00);
      check("R1 irq/sck_oe/ser_oe", {5'd0, irq, sck_oe, ser_oe}, 8'h00);

      // table walk: master exchanges with loopback
      for (int v = 0; v < 4; v++) begin
         logic [1:0] rt;
         logic [7:0] tx, ex;
         int h;
         rt = VEC[v][23:22];
         loop_inv = VEC[v][21];
         tx = VEC[v][15:8];
         ex = VEC[v][7:0];
         h = half_of(rt);
         bus_write(2'd0, 8'h07 | {2'b00, rt, 4'h0});
         bus_write(2'd2, tx);
         repeat (16 * h - 1) @(posedge clk);
         @(negedge clk);
         check("R2 irq not yet due", {7'd0, irq}, 8'h00);
         @(posedge clk);
         @(negedge clk);
         check("R2 R10 irq due at 16*H edges", {7'd0, irq}, 8'h01);
         check("R3 sck idle low after exchange", {6'd0, sck_out, sck_oe}, 8'h01);
         bus_read(2'd1, rd); check("R4 status finished bit 7", rd, 8'h80);
         bus_read(2'd2, rd); check("R3 received byte", rd, ex);
         bus_read(2'd1, rd); check("R5 finished flag cleared", rd, 8'h00);
         check("R10 irq low after clear", {7'd0, irq}, 8'h00);
      end
      loop_inv = 1'b0;

      // R6/R7: write collision, interrupt enable off
      bus_write(2'd0, 8'h33);
      bus_write(2'd2, 8'h55);
      bus_write(2'd2, 8'hAA);
      repeat (16 * 16 + 4) @(posedge clk);
      @(negedge clk);
      check("R10 irq low with ie clear", {7'd0, irq}, 8'h00);
      bus_read(2'd1, rd); check("R6 status finished and collision", rd, 8'hC0);
      bus_read(2'd2, rd); check("R6 shifted byte not overwritten", rd, 8'h55);
      bus_read(2'd1, rd); check("R7 collision and finished cleared", rd, 8'h00);

      // R6: collision alone raises no interrupt
      bus_write(2'd0, 8'h37);
      bus_write(2'd2, 8'h11);
      bus_write(2'd2, 8'h22);
      @(negedge clk);
      check("R6 no irq from collision", {7'd0, irq}, 8'h00);
      repeat (16 * 16 + 4) @(posedge clk);
      @(negedge clk);
      check("R10 irq from finished", {7'd0, irq}, 8'h01);

      // R5/R12: data access without armed read does not clear; arm survives
      bus_read(2'd2, rd);
      bus_read(2'd1, rd); check("R5 unarmed data read leaves flags", rd, 8'hC0);
      bus_write(2'd0, 8'h37);
      bus_read(2'd0, rd);
      bus_read(2'd2, rd);
      bus_read(2'd1, rd); check("R12 arm survives other accesses", rd, 8'h00);

      // R8/R9: mode fault
      bus_write(2'd0, 8'h07);
      @(negedge clk);
      ss_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R8 fault not before third edge", {7'd0, irq}, 8'h00);
      @(posedge clk);
      @(negedge clk);
      check("R8 R10 fault irq on third edge", {7'd0, irq}, 8'h01);
      check("R8 drivers released", {6'd0, sck_oe, ser_oe}, 8'h00);
      bus_read(2'd0, rd); check("R8 enable and master cleared", rd, 8'h04);
      bus_write(2'd0, 8'h04);
      bus_read(2'd1, rd); check("R9 unarmed control write keeps fault", rd, 8'h10);
      bus_read(2'd2, rd);
      bus_read(2'd1, rd); check("R9 data access keeps fault", rd, 8'h10);
      ss_n = 1'b1;
      bus_write(2'd0, 8'h04);
      bus_read(2'd1, rd); check("R9 fault cleared by armed control write", rd, 8'h00);

      // R11: slave mode
      use_ext = 1'b1;
      bus_write(2'd0, 8'h01);
      bus_write(2'd2, 8'h96);
      for (int p = 0; p < 3; p++) begin
         @(negedge clk); sck_in = 1'b1;
         repeat (6) @(posedge clk);
         @(negedge clk); sck_in = 1'b0;
         repeat (6) @(posedge clk);
      end
      @(negedge clk);
      ss_n = 1'b0;
      repeat (6) @(posedge clk);
      @(negedge clk);
      check("R11 slave drives when selected", {7'd0, ser_oe}, 8'h01);
      obs = 8'h00;
      for (int b = 7; b >= 0; b--) begin
         logic [7:0] pat;
         pat = 8'h5B;
         ext_bit = pat[b];
         repeat (6) @(posedge clk);
         @(negedge clk);
         obs[b] = ser_out;
         sck_in = 1'b1;
         repeat (6) @(posedge clk);
         @(negedge clk);
         sck_in = 1'b0;
      end
      repeat (6) @(posedge clk);
      @(negedge clk);
      check("R11 slave sent preloaded byte", obs, 8'h96);
      bus_read(2'd1, rd); check("R11 slave finished flag", rd, 8'h80);
      bus_read(2'd2, rd); check("R11 slave received byte", rd, 8'h5B);
      ss_n = 1'b1;

      finish_run();
   end
endmodule